// File: doc/BRIEF.md
# Binary-Field Almost-Inverse Unit

This block finds the multiplicative inverse of a nonzero element of GF(2^M). Elements use polynomial basis: bit i of a word is the coefficient of x^i. The fixed reduction polynomial is the trinomial f = x^M + x^TAP + 1. The defaults are M = 127 and TAP = 1.

The computation runs in two stages:

- **Stage one (reduction loop).** It works on four (M+1)-bit polynomials u, v, b and c, and keeps an exponent k. It ends with b·a ≡ x^k (mod f).
- **Stage two (correction).** It strips the x^k factor from b, removing STEP factors of x per cycle.

The unit never searches a whole word for its leading one. The degrees of u and v are carried from step to step. When a sum of two operands of equal degree cancels its top term, the new degree is recovered by shifting a probe copy toward bit M. The unit counts those shifts and looks at only a four-bit window at the top of the probe.

A host pulses `start_i` with an operand while the unit is idle. `busy_o` stays high during the computation. `done_o` pulses once when the result is ready. A zero operand is refused at once with an error flag.

Top module: `gfinv_almost`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `zero_err_o` and `result_o` are all zero.
- R2: For a nonzero operand a, the result r satisfies a·r ≡ 1 (mod x^M + x^TAP + 1). Here bit i of each word is the coefficient of x^i.
- R3: A start with a zero operand completes in the next cycle with `done_o`=1, `zero_err_o`=1 and `result_o`=0, and `busy_o` stays low.
- R4: `zero_err_o` and `result_o` change only in a cycle where `done_o` is high. `zero_err_o` is 0 on completion of a nonzero operand.
- R5: `start_i` and `operand_i` are ignored while `busy_o` is high. The running inverse is not altered and no extra completion appears.
- R6: `busy_o` rises in the cycle after an accepted nonzero start and falls in the same cycle that `done_o` pulses. `done_o` and `busy_o` are never high together. The run takes at most (2M+1)(M+2)+2M+4 cycles.
- R7: Corner operands give exact values: operand 1 returns 1, and operand x returns x^(M-1) + x^(TAP-1).
- R8: A start presented in the cycle where `done_o` is high is accepted. Its result is computed from the new operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an inverse when idle |
| operand_i | input | M | Field element to invert |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| zero_err_o | output | 1 | Last completed operand was zero |
| result_o | output | M | Inverse of the last operand (held) |

## Verification
Two things can happen in one cycle.

- **Inside the loop.** A loop cycle with odd u does the swap decision, the addition and the division by x together. Operands of full degree (all-ones, x^(M-1)) and random operands push the loop through both degree-differing and equal-degree additions. The correctness of every merged step is judged by multiplying each result back against its operand with an independent shift-and-add multiplier.
- **At the interface.** A completion and a new start can land on the same edge. The bench issues the next operand in the very cycle `done_o` is seen. It then checks that both results come out in order and both are correct inverses.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_NORM = 2'd1,
        S_LOOP = 2'd2,
        S_CORR = 2'd3
    } gfinv_state_e;
endpackage

// File: rtl/gfinv_lead_align.sv
// Degree recovery: moves the probe toward bit M by up to four places per
// cycle, looking only at a four-bit window at the top.
module gfinv_lead_align #(
    parameter int M  = 127,
    parameter int DW = 8
) (
    input  logic [M:0]    p_i,
    input  logic [DW-1:0] cnt_i,
    output logic [M:0]    p_o,
    output logic [DW-1:0] cnt_o,
    output logic          aligned_o
);
    logic [2:0] sh;

    always_comb begin
        if (p_i[M])        sh = 3'd0;
        else if (p_i[M-1]) sh = 3'd1;
        else if (p_i[M-2]) sh = 3'd2;
        else if (p_i[M-3]) sh = 3'd3;
        else               sh = 3'd4;
    end

    assign aligned_o = p_i[M];
    assign p_o       = p_i << sh;
    assign cnt_o     = cnt_i + DW'(sh);
endmodule

// File: rtl/gfinv_loop_step.sv
// One merged reduction step for odd u: swap on degree, add, divide by x.
module gfinv_loop_step #(
    parameter int M  = 127,
    parameter int DW = 8
) (
    input  logic [M:0]    u_i,
    input  logic [M:0]    v_i,
    input  logic [M:0]    b_i,
    input  logic [M:0]    c_i,
    input  logic [DW-1:0] du_i,
    input  logic [DW-1:0] dv_i,
    output logic [M:0]    u_o,
    output logic [M:0]    v_o,
    output logic [M:0]    b_o,
    output logic [M:0]    c_o,
    output logic [DW-1:0] du_o,
    output logic [DW-1:0] dv_o,
    output logic          renorm_o
);
    logic          swap;
    logic [M:0]    us, vs, bs, cs, sum;
    logic [DW-1:0] dus, dvs;

    assign swap = du_i < dv_i;
    assign us   = swap ? v_i : u_i;
    assign vs   = swap ? u_i : v_i;
    assign bs   = swap ? c_i : b_i;
    assign cs   = swap ? b_i : c_i;
    assign dus  = swap ? dv_i : du_i;
    assign dvs  = swap ? du_i : dv_i;

    assign sum      = us ^ vs;
    assign u_o      = sum >> 1;
    assign v_o      = vs;
    assign b_o      = bs ^ cs;
    assign c_o      = cs << 1;
    assign du_o     = dus - DW'(1);
    assign dv_o     = dvs;
    assign renorm_o = (dus == dvs);
endmodule

// File: rtl/gfinv_xk_strip.sv
// Stage-two correction: removes up to STEP factors of x per cycle.
module gfinv_xk_strip #(
    parameter int         M    = 127,
    parameter int         KW   = 9,
    parameter int         STEP = 4,
    parameter logic [M:0] POLY = '0
) (
    input  logic [M:0]    b_i,
    input  logic [KW-1:0] krem_i,
    output logic [M:0]    b_o,
    output logic [KW-1:0] krem_o
);
    logic [STEP:0][M:0] chain;

    assign chain[0] = b_i;

    for (genvar i = 0; i < STEP; i++) begin : g_stage
        logic [M:0] fixed;
        assign fixed      = chain[i][0] ? (chain[i] ^ POLY) : chain[i];
        assign chain[i+1] = (krem_i > KW'(i)) ? (fixed >> 1) : chain[i];
    end

    assign b_o    = chain[STEP];
    assign krem_o = (krem_i > KW'(STEP)) ? (krem_i - KW'(STEP)) : '0;
endmodule

// File: rtl/gfinv_almost.sv
module gfinv_almost #(
    parameter int M    = 127,
    parameter int TAP  = 1,
    parameter int STEP = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [M-1:0] operand_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         zero_err_o,
    output logic [M-1:0] result_o
);
    import gfinv_pkg::*;

    localparam int W  = M + 1;
    localparam int DW = $clog2(M + 2);
    localparam int KW = $clog2(2 * M + 2) + 1;
    localparam logic [W-1:0] POLY = (W'(1) << M) | (W'(1) << TAP) | W'(1);

    typedef struct packed {
        gfinv_state_e  st;
        logic [W-1:0]  u;
        logic [W-1:0]  v;
        logic [W-1:0]  b;
        logic [W-1:0]  c;
        logic [W-1:0]  p;
        logic [DW-1:0] du;
        logic [DW-1:0] dv;
        logic [DW-1:0] pc;
        logic [KW-1:0] k;
        logic [M-1:0]  res;
        logic          done;
        logic          err;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [W-1:0]  al_p;
    logic [DW-1:0] al_cnt;
    logic          al_ok;
    logic [W-1:0]  st_u, st_v, st_b, st_c;
    logic [DW-1:0] st_du, st_dv;
    logic          st_renorm;
    logic [W-1:0]  xs_b;
    logic [KW-1:0] xs_k;
    logic [W-1:0]  b_red;
    logic [KW-1:0] k_mon;

    gfinv_lead_align #(.M(M), .DW(DW)) u_align (
        .p_i      (ctx_q.p),
        .cnt_i    (ctx_q.pc),
        .p_o      (al_p),
        .cnt_o    (al_cnt),
        .aligned_o(al_ok)
    );

    gfinv_loop_step #(.M(M), .DW(DW)) u_step (
        .u_i     (ctx_q.u),
        .v_i     (ctx_q.v),
        .b_i     (ctx_q.b),
        .c_i     (ctx_q.c),
        .du_i    (ctx_q.du),
        .dv_i    (ctx_q.dv),
        .u_o     (st_u),
        .v_o     (st_v),
        .b_o     (st_b),
        .c_o     (st_c),
        .du_o    (st_du),
        .dv_o    (st_dv),
        .renorm_o(st_renorm)
    );

    gfinv_xk_strip #(.M(M), .KW(KW), .STEP(STEP), .POLY(POLY)) u_strip (
        .b_i   (ctx_q.b),
        .krem_i(ctx_q.k),
        .b_o   (xs_b),
        .krem_o(xs_k)
    );

    assign b_red = ctx_q.b[M] ? (ctx_q.b ^ POLY) : ctx_q.b;

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        unique case (ctx_q.st)
            S_IDLE: begin
                if (start_i) begin
                    if (operand_i == '0) begin
                        ctx_d.done = 1'b1;
                        ctx_d.err  = 1'b1;
                        ctx_d.res  = '0;
                    end else begin
                        ctx_d.u  = {1'b0, operand_i};
                        ctx_d.v  = POLY;
                        ctx_d.b  = W'(1);
                        ctx_d.c  = '0;
                        ctx_d.k  = '0;
                        ctx_d.dv = DW'(M);
                        ctx_d.p  = {1'b0, operand_i};
                        ctx_d.pc = '0;
                        ctx_d.st = S_NORM;
                    end
                end
            end
            S_NORM: begin
                if (al_ok) begin
                    ctx_d.du = DW'(M) - ctx_q.pc;
                    ctx_d.st = S_LOOP;
                end else begin
                    ctx_d.p  = al_p;
                    ctx_d.pc = al_cnt;
                end
            end
            S_LOOP: begin
                if (!ctx_q.u[0]) begin
                    ctx_d.u  = ctx_q.u >> 1;
                    ctx_d.c  = ctx_q.c << 1;
                    ctx_d.k  = ctx_q.k + KW'(1);
                    ctx_d.du = ctx_q.du - DW'(1);
                end else if (ctx_q.du == '0) begin
                    ctx_d.st = S_CORR;
                end else begin
                    ctx_d.u  = st_u;
                    ctx_d.v  = st_v;
                    ctx_d.b  = st_b;
                    ctx_d.c  = st_c;
                    ctx_d.dv = st_dv;
                    ctx_d.k  = ctx_q.k + KW'(1);
                    if (st_renorm) begin
                        ctx_d.p  = st_u;
                        ctx_d.pc = '0;
                        ctx_d.st = S_NORM;
                    end else begin
                        ctx_d.du = st_du;
                    end
                end
            end
            S_CORR: begin
                if (ctx_q.k == '0) begin
                    ctx_d.res  = b_red[M-1:0];
                    ctx_d.err  = 1'b0;
                    ctx_d.done = 1'b1;
                    ctx_d.st   = S_IDLE;
                end else begin
                    ctx_d.b = xs_b;
                    ctx_d.k = xs_k;
                end
            end
            default: ctx_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctx_q <= '0;
        else         ctx_q <= ctx_d;
    end

    assign busy_o     = (ctx_q.st != S_IDLE);
    assign done_o     = ctx_q.done;
    assign zero_err_o = ctx_q.err;
    assign result_o   = ctx_q.res;
    assign k_mon      = ctx_q.k;
endmodule

// File: rtl/gfinv_almost_chk.sv
module gfinv_almost_chk #(
    parameter int M  = 127,
    parameter int KW = 9
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic [M-1:0]  operand_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          zero_err_o,
    input logic [M-1:0]  result_o,
    input logic [KW-1:0] k_i
);
    localparam int LAT = (2 * M + 1) * (M + 2) + 2 * M + 4;
    localparam int LW  = $clog2(LAT + 2) + 1;

    logic [LW-1:0] run_cnt;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)     run_cnt <= '0;
        else if (busy_o) run_cnt <= run_cnt + LW'(1);
        else             run_cnt <= '0;
    end

    assert_done_not_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    assert_busy_ends_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

    assert_latency_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_cnt <= LW'(LAT));

    assert_exponent_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        k_i <= KW'(2 * M));

    assert_zero_refused_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && operand_i == '0) |=> (done_o && zero_err_o && result_o == '0 && !busy_o));

    assert_flag_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(zero_err_o) && $stable(result_o)));

    assert_nonzero_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !zero_err_o) |-> (result_o != '0));

    assert_result_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> $stable(result_o));

    assert_restart_on_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && start_i && operand_i != '0) |=> busy_o);
endmodule

bind gfinv_almost gfinv_almost_chk #(.M(M), .KW(KW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .operand_i (operand_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .zero_err_o(zero_err_o),
    .result_o  (result_o),
    .k_i       (k_mon)
);

// File: tb/test_gfinv_almost.sv
module test_gfinv_almost;
    localparam int M   = 127;
    localparam int TAP = 1;
    localparam int LAT = (2 * M + 1) * (M + 2) + 2 * M + 4;
    localparam logic [M:0] FP = ((M+1)'(1) << M) | ((M+1)'(1) << TAP) | (M+1)'(1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] operand = '0;
    logic         busy, done, zerr;
    logic [M-1:0] result;

    int unsigned n_run = 0, n_fail = 0, cycle = 0;

    typedef struct {
        logic [M-1:0] op;
        bit           is_zero;
        bit           exact;
        logic [M-1:0] want;
        int unsigned  t0;
        string        tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    gfinv_almost #(.M(M), .TAP(TAP), .STEP(4)) i_gfinv_almost (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .operand_i (operand),
        .busy_o    (busy),
        .done_o    (done),
        .zero_err_o(zerr),
        .result_o  (result)
    );

    function automatic logic [M-1:0] gmul(input logic [M-1:0] x, input logic [M-1:0] y);
        logic [M:0] acc;
        logic [M:0] sh;
        acc = '0;
        sh  = {1'b0, x};
        for (int i = 0; i < M; i++) begin
            if (y[i]) acc = acc ^ sh;
            sh = sh << 1;
            if (sh[M]) sh = sh ^ FP;
        end
        return acc[M-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: presents one start at the current negedge and records the expectation.
    task automatic launch(input logic [M-1:0] op, input bit exact, input logic [M-1:0] want, input string tag);
        item_t it;
        it.op = op; it.is_zero = (op == '0); it.exact = exact; it.want = want;
        it.t0 = cycle; it.tag = tag;
        sb.push_back(it);
        start = 1'b1; operand = op;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic one(input logic [M-1:0] op, input bit exact, input logic [M-1:0] want, input string tag);
        launch(op, exact, want, tag);
        drain();
    endtask

    // Monitor: pops the oldest expectation at every completion.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R5 unexpected completion", result, '0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(busy == 1'b0, "R6 busy low at done", M'(busy), '0);
                check((cycle - it.t0) <= LAT, "R6 latency", M'(cycle - it.t0), M'(LAT));
                if (it.is_zero) begin
                    check(zerr == 1'b1, "R3 zero flag", M'(zerr), M'(1));
                    check(result == '0, "R3 zero result", result, '0);
                end else begin
                    check(zerr == 1'b0, "R4 flag cleared", M'(zerr), '0);
                    check(gmul(it.op, result) == M'(1), {it.tag, " product"}, gmul(it.op, result), M'(1));
                    if (it.exact) check(result == it.want, {it.tag, " exact"}, result, it.want);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", '0, '0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [M-1:0] r;
        logic [M-1:0] xinv;
        xinv = (M'(1) << (M - 1)) | (M'(1) << (TAP - 1));
        repeat (3) @(negedge clk);
        // R1: reset values
        check(!busy && !done && !zerr && result == '0, "R1 reset state",
              {result[M-1:3], busy, done, zerr}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: exact corner values
        one(M'(1), 1'b1, M'(1), "R7 one");
        one(M'(2), 1'b1, xinv, "R7 x");

        // R2: full-degree and structured operands
        one({M{1'b1}}, 1'b0, '0, "R2 all-ones");
        one(M'(1) << (M - 1), 1'b0, '0, "R2 top power");
        one((M'(1) << TAP) | M'(1), 1'b0, '0, "R2 low trinomial part");
        one(M'(3) << 60, 1'b0, '0, "R2 even operand");
        for (int i = 0; i < 6; i++) begin
            r = M'({$urandom, $urandom, $urandom, $urandom});
            if (r == '0) r = M'(5);
            one(r, 1'b0, '0, "R2 random");
        end

        // R6: busy rises the cycle after an accepted start
        launch(M'(12345), 1'b0, '0, "R2 busy probe");
        check(busy == 1'b1, "R6 busy after start", M'(busy), M'(1));
        drain();

        // R3 then R4: zero refused, flag held, then cleared by a nonzero run
        launch('0, 1'b0, '0, "R3");
        check(busy == 1'b0, "R3 busy stays low", M'(busy), '0);
        drain();
        repeat (3) @(negedge clk);
        check(zerr == 1'b1 && result == '0, "R4 flag held", M'(zerr), M'(1));
        one(M'(7), 1'b0, '0, "R4 after zero");

        // R5: start with a different operand while busy is ignored
        launch(M'(99), 1'b0, '0, "R5 first");
        repeat (5) @(negedge clk);
        start = 1'b1; operand = {M{1'b1}};
        @(negedge clk);
        start = 1'b0; operand = '0;
        drain();
        repeat (20) @(negedge clk);
        check(sb.size() == 0 && !busy, "R5 no extra run", M'(busy), '0);

        // R8: next start in the done cycle
        launch(M'(1234567), 1'b0, '0, "R8 first");
        do @(negedge clk); while (!done);
        launch(M'(2) << 90 | M'(9), 1'b0, '0, "R8 second");
        drain();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule